// File: doc/BRIEF.md
# Oscillator Band Autoselect Controller

This controller picks one of 24 oscillator bands for a frequency synthesizer. In automatic mode a start pulse begins a search at a band that firmware programs. The controller holds each band for a fixed settling interval. It then reads a 3-bit tuning-voltage code and acts on it: it accepts the band, moves one band down, moves one band up, or gives up. Two flags report the outcome. One flag shows whether the search has stopped, and the other shows whether it succeeded. The selected band is kept in a readback register.

In manual mode the programmed band drives the oscillator directly. Firmware can sample the tuning-voltage code and copy the sample into a readback register. The charge-pump current is either chosen by the controller (high while searching, low otherwise) or taken straight from a firmware bit. The ADC and the loop are outside the block. The bench models them.

Top module: `vco_band_autoselect`

## Requirements
- R1: After reset, searchIdle is 1 and searchOk is 0, both readback registers are 0, and cpHigh is 0 when cpAutoMode is 1.
- R2: In automatic mode (autoEn=1), a one-cycle startPulse clears searchIdle and searchOk on the next clock and sets activeBand to startBand. When autoEn=0, startPulse has no effect on the flags.
- R3: Every band the search tries is held for SETTLE_CYCLES clocks before its code is judged. A search that tries k bands keeps searchIdle at 0 for exactly SETTLE_CYCLES*k cycles.
- R4: Codes 3'b010 and 3'b101 are the only accepted codes. Accepting a band sets searchIdle=1 and searchOk=1 and loads that band into bandReadback.
- R5: Codes 3'b000, 3'b001 and 3'b011 step the band down by one. Codes 3'b110, 3'b111 and 3'b100 step it up by one. The lock codes 001 and 110 are therefore not accepted.
- R6: A step that would go below band 0 or above band 23 ends the search with searchIdle=1 and searchOk=0, and bandReadback is left unchanged.
- R7: A step into a band already tried in the same search ends the search as a failure, in the same way as R6.
- R8: A startPulse during a running search restarts it from the current startBand. The search timing then counts from the new pulse.
- R9: A startBand above 23 with autoEn=1 ends at once as a failure (searchIdle=1, searchOk=0 on the next clock).
- R10: When autoEn=0, activeBand equals startBand. The code is sampled only on clocks with adcReadEn=1. adcLatch=1 copies the last sample into adcReadback. With autoEn=1 both of these inputs are ignored.
- R11: With cpAutoMode=1, cpHigh is 1 exactly while a search runs. With cpAutoMode=0, cpHigh equals cpManualHigh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Starts or restarts a search |
| autoEn | input | 1 | 1 = automatic search, 0 = manual band |
| startBand | input | 5 | Programmed band; search start point |
| adcCode | input | 3 | Tuning-voltage code |
| adcReadEn | input | 1 | Manual: sample adcCode this clock |
| adcLatch | input | 1 | Manual: copy sample into adcReadback |
| cpAutoMode | input | 1 | 1 = controller picks charge-pump current |
| cpManualHigh | input | 1 | Firmware current choice (1 = high) |
| activeBand | output | 5 | Band driven to the oscillator |
| searchIdle | output | 1 | 1 = no search running |
| searchOk | output | 1 | 1 = last search succeeded |
| bandReadback | output | 5 | Band chosen by the last successful search |
| adcReadback | output | 3 | Latched manual code |
| cpHigh | output | 1 | 1 = high charge-pump current |

## Verification
A new start pulse can arrive on the same clock edge on which the running search judges its code. If the verdict won, the flags would report a finished search that firmware has just replaced. The bench provokes this collision by issuing restarts part-way through a settle window and checking that only the restarted search sets the flags. It also sweeps every start band against every target band, and against no-lock and oscillating code profiles. For each case the outcome, the readback and the exact busy length are compared with values computed from the band distance.

// File: rtl/vas_pkg.sv
package vas_pkg;

  typedef struct packed {
    logic start;
    logic stepUp;
    logic stepDown;
    logic commit;
  } vasStrobe_t;

  typedef enum logic [1:0] {
    CODE_ACCEPT = 2'd0,
    CODE_DOWN   = 2'd1,
    CODE_UP     = 2'd2
  } codeClass_t;

  function automatic codeClass_t classifyCode(input logic [2:0] code);
    if (code == 3'b010 || code == 3'b101) return CODE_ACCEPT;
    else if (code[2] == 1'b0)             return CODE_DOWN;
    else                                  return CODE_UP;
  endfunction

endpackage

// File: rtl/vas_ctrl.sv
module vas_ctrl
  import vas_pkg::*;
#(
  parameter int NUM_BANDS     = 24,
  parameter int BAND_W        = 5,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              autoEn,
  input  logic [BAND_W-1:0] startBand,
  input  logic [2:0]        adcCode,
  input  logic [BAND_W-1:0] curBand,
  input  logic              visitedUp,
  input  logic              visitedDown,
  output vasStrobe_t        strobe,
  output logic              searchIdle,
  output logic              searchOk,
  output logic              searching
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [BAND_W-1:0] LAST_BAND = BAND_W'(NUM_BANDS - 1);
  localparam logic [CNT_W-1:0]  CNT_LOAD  = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_SETTLE} state_t;

  state_t           state;
  logic [CNT_W-1:0] settleCnt;
  logic             startNow, startValid, evalNow, failNow;
  logic             downBlock, upBlock;
  codeClass_t       cls;

  always_comb begin
    startNow   = startPulse && autoEn;
    startValid = startBand <= LAST_BAND;
    evalNow    = (state == ST_SETTLE) && (settleCnt == '0) && !startNow;
    cls        = classifyCode(adcCode);
    downBlock  = (curBand == '0) || visitedDown;
    upBlock    = (curBand == LAST_BAND) || visitedUp;
    strobe          = '0;
    strobe.start    = startNow && startValid;
    strobe.commit   = evalNow && (cls == CODE_ACCEPT);
    strobe.stepDown = evalNow && (cls == CODE_DOWN) && !downBlock;
    strobe.stepUp   = evalNow && (cls == CODE_UP) && !upBlock;
    failNow = (startNow && !startValid) ||
              (evalNow && (((cls == CODE_DOWN) && downBlock) ||
                           ((cls == CODE_UP) && upBlock)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      settleCnt  <= '0;
      searchIdle <= 1'b1;
      searchOk   <= 1'b0;
    end else if (startNow) begin
      state      <= startValid ? ST_SETTLE : ST_IDLE;
      settleCnt  <= CNT_LOAD;
      searchIdle <= !startValid;
      searchOk   <= 1'b0;
    end else if (evalNow) begin
      if (strobe.commit) begin
        state      <= ST_IDLE;
        searchIdle <= 1'b1;
        searchOk   <= 1'b1;
      end else if (failNow) begin
        state      <= ST_IDLE;
        searchIdle <= 1'b1;
        searchOk   <= 1'b0;
      end else begin
        settleCnt  <= CNT_LOAD;
      end
    end else if (state == ST_SETTLE) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  assign searching = (state == ST_SETTLE);

  // R4: success is only ever reported on a stopped search
  a_r4_ok_implies_idle: assert property (@(posedge clk) disable iff (!rstN)
    searchOk |-> searchIdle);

  // R8: a start in automatic mode always clears the success flag
  a_r8_start_clears_ok: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && autoEn) |=> !searchOk);

  // R2: in manual mode a start pulse leaves the flags alone
  a_r2_manual_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !autoEn && searchIdle) |=> ($stable(searchOk) && searchIdle));

  // R3: settle counter never exceeds its load value
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    settleCnt <= CNT_LOAD);

endmodule

// File: rtl/vas_dp.sv
module vas_dp
  import vas_pkg::*;
#(
  parameter int NUM_BANDS = 24,
  parameter int BAND_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  vasStrobe_t        strobe,
  input  logic              autoEn,
  input  logic [BAND_W-1:0] startBand,
  input  logic [2:0]        adcCode,
  input  logic              adcReadEn,
  input  logic              adcLatch,
  output logic [BAND_W-1:0] curBand,
  output logic              visitedUp,
  output logic              visitedDown,
  output logic [BAND_W-1:0] bandReadback,
  output logic [2:0]        adcReadback
);

  localparam logic [BAND_W-1:0] LAST_BAND = BAND_W'(NUM_BANDS - 1);

  logic [NUM_BANDS-1:0] visited;
  logic [2:0]           adcSample;
  logic [BAND_W-1:0]    nextBand;

  always_comb begin
    visitedUp   = (curBand < LAST_BAND) ? visited[curBand + 1'b1] : 1'b1;
    visitedDown = (curBand != '0)       ? visited[curBand - 1'b1] : 1'b1;
    if (strobe.start)         nextBand = startBand;
    else if (strobe.stepUp)   nextBand = curBand + 1'b1;
    else if (strobe.stepDown) nextBand = curBand - 1'b1;
    else                      nextBand = curBand;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBand <= '0;
    end else begin
      curBand <= nextBand;
    end
  end

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_visit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        visited[b] <= 1'b0;
      else if (strobe.start)
        visited[b] <= (startBand == BAND_W'(b));
      else if ((strobe.stepUp || strobe.stepDown) && nextBand == BAND_W'(b))
        visited[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bandReadback <= '0;
      adcSample    <= '0;
      adcReadback  <= '0;
    end else begin
      if (strobe.commit)          bandReadback <= curBand;
      if (!autoEn && adcReadEn)   adcSample    <= adcCode;
      if (!autoEn && adcLatch)    adcReadback  <= adcSample;
    end
  end

  // R5: a step moves the band by exactly one
  a_r5_step_up_one: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepUp && !strobe.start) |=> (curBand == $past(curBand) + 1'b1));

  // R6: the band register never leaves the legal range
  a_r6_band_in_range: assert property (@(posedge clk) disable iff (!rstN)
    curBand <= LAST_BAND);

  // R10: readback only changes on a manual latch
  a_r10_readback_hold: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn || !adcLatch) |=> $stable(adcReadback));

  // R7: a step never lands on a band already tried
  a_r7_no_revisit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDown && !strobe.start) |-> !visitedDown);

endmodule

// File: rtl/vco_band_autoselect.sv
module vco_band_autoselect
  import vas_pkg::*;
#(
  parameter int NUM_BANDS     = 24,
  parameter int BAND_W        = 5,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              autoEn,
  input  logic [BAND_W-1:0] startBand,
  input  logic [2:0]        adcCode,
  input  logic              adcReadEn,
  input  logic              adcLatch,
  input  logic              cpAutoMode,
  input  logic              cpManualHigh,
  output logic [BAND_W-1:0] activeBand,
  output logic              searchIdle,
  output logic              searchOk,
  output logic [BAND_W-1:0] bandReadback,
  output logic [2:0]        adcReadback,
  output logic              cpHigh
);

  vasStrobe_t        strobe;
  logic [BAND_W-1:0] curBand;
  logic              visitedUp, visitedDown, searching;

  vas_ctrl #(
    .NUM_BANDS(NUM_BANDS), .BAND_W(BAND_W), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .autoEn(autoEn),
    .startBand(startBand), .adcCode(adcCode), .curBand(curBand),
    .visitedUp(visitedUp), .visitedDown(visitedDown), .strobe(strobe),
    .searchIdle(searchIdle), .searchOk(searchOk), .searching(searching)
  );

  vas_dp #(
    .NUM_BANDS(NUM_BANDS), .BAND_W(BAND_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .autoEn(autoEn),
    .startBand(startBand), .adcCode(adcCode), .adcReadEn(adcReadEn),
    .adcLatch(adcLatch), .curBand(curBand), .visitedUp(visitedUp),
    .visitedDown(visitedDown), .bandReadback(bandReadback),
    .adcReadback(adcReadback)
  );

  assign activeBand = autoEn ? curBand : startBand;
  assign cpHigh     = cpAutoMode ? searching : cpManualHigh;

  // R11: automatic current is high only while a search is running
  a_r11_cp_auto: assert property (@(posedge clk) disable iff (!rstN)
    (cpAutoMode && searchIdle) |-> !cpHigh);

endmodule

// File: tb/vco_band_autoselect_tb_top.sv
`timescale 1ns/1ps
module vco_band_autoselect_tb_top;

  localparam int S = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0, autoEn = 1'b1;
  logic [4:0] startBand = '0;
  logic [2:0] adcCode;
  logic       adcReadEn = 1'b0, adcLatch = 1'b0;
  logic       cpAutoMode = 1'b1, cpManualHigh = 1'b0;
  logic [4:0] activeBand, bandReadback;
  logic [2:0] adcReadback;
  logic       searchIdle, searchOk, cpHigh;

  int  mode = 0;   // 0: window at tgt, 1: oscillate around pivot tgt
  int  tgt  = 0;
  logic       useForce = 1'b0;
  logic [2:0] forceCode = '0;
  int  nChecks = 0, nFails = 0;
  int  expReadback = 0;
  bit  done = 0;

  always #4 clk = ~clk;

  function automatic logic [2:0] modelCode(input int band, input int m, input int t);
    logic [2:0] upC[3];
    logic [2:0] dnC[3];
    upC = '{3'b110, 3'b111, 3'b100};
    dnC = '{3'b000, 3'b001, 3'b011};
    if (m == 0) begin
      if (band == t)     return (band % 2 == 0) ? 3'b010 : 3'b101;
      else if (band < t) return upC[band % 3];
      else               return dnC[band % 3];
    end else begin
      if (band <= t)     return upC[band % 3];
      else               return dnC[band % 3];
    end
  endfunction

  assign adcCode = useForce ? forceCode : modelCode(int'(activeBand), mode, tgt);

  vco_band_autoselect #(.SETTLE_CYCLES(S)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .autoEn(autoEn),
    .startBand(startBand), .adcCode(adcCode), .adcReadEn(adcReadEn),
    .adcLatch(adcLatch), .cpAutoMode(cpAutoMode), .cpManualHigh(cpManualHigh),
    .activeBand(activeBand), .searchIdle(searchIdle), .searchOk(searchOk),
    .bandReadback(bandReadback), .adcReadback(adcReadback), .cpHigh(cpHigh)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart(input int s);
    startBand  = 5'(s);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  // count cycles with searchIdle low, starting at the negedge after the start edge
  task automatic waitDone(output int n);
    n = 0;
    while (!searchIdle && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic runSearch(input int s, input bit expOk, input int tried, input string tag);
    int n;
    pulseStart(s);
    check(activeBand == 5'(s), "R2 start band", activeBand, s);
    check(cpHigh == 1'b1, "R11 cp high while searching", cpHigh, 1);
    waitDone(n);
    check(n == S * tried, {"R3 busy length ", tag}, n, S * tried);
    check(searchOk == expOk, {"R4/R6/R7 outcome ", tag}, searchOk, expOk);
    if (expOk) expReadback = tgt;
    check(bandReadback == 5'(expReadback), {"R4/R6 readback ", tag}, bandReadback, expReadback);
    check(cpHigh == 1'b0, "R11 cp low when idle", cpHigh, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(searchIdle == 1'b1, "R1 idle", searchIdle, 1);
    check(searchOk == 1'b0, "R1 ok", searchOk, 0);
    check(bandReadback == 5'd0, "R1 band readback", bandReadback, 0);
    check(adcReadback == 3'd0, "R1 adc readback", adcReadback, 0);
    check(cpHigh == 1'b0, "R1 cp", cpHigh, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R5 R6: every start band against every target, plus no-lock profiles
    mode = 0;
    for (int t = -1; t <= 24; t++) begin
      tgt = t;
      for (int s = 0; s < 24; s++) begin
        if (t < 0)       runSearch(s, 1'b0, s + 1, "R6 low edge");
        else if (t > 23) runSearch(s, 1'b0, 24 - s, "R6 high edge");
        else             runSearch(s, 1'b1, (t > s ? t - s : s - t) + 1, "R5 walk");
      end
    end

    // R7: oscillating profile forces a revisit
    mode = 1;
    for (int p = 0; p < 23; p++) begin
      tgt = p;
      for (int s = 0; s < 24; s += 3) begin
        runSearch(s, 1'b0, (s <= p) ? (p + 2 - s) : (s - p + 1), "R7 revisit");
      end
    end

    // R8: restart part-way through, including on a verdict edge
    mode = 0; tgt = 20;
    for (int k = 1; k <= 2 * S; k++) begin
      pulseStart(5);
      repeat (k - 1) @(negedge clk);
      pulseStart(18);
      check(searchOk == 1'b0 && searchIdle == 1'b0, "R8 restart busy", searchIdle, 0);
      check(activeBand == 5'd18, "R8 restart band", activeBand, 18);
      waitDone(n);
      check(n == S * 3, "R8 restart length", n, S * 3);
      check(searchOk == 1'b1 && bandReadback == 5'd20, "R8 restart result", bandReadback, 20);
    end
    expReadback = 20;

    // R9: start band out of range
    for (int s = 24; s < 32; s++) begin
      pulseStart(s);
      check(searchIdle == 1'b1 && searchOk == 1'b0, "R9 bad start", searchOk, 0);
      check(bandReadback == 5'(expReadback), "R9 readback kept", bandReadback, expReadback);
    end

    // R2 R10: manual mode
    tgt = 7;
    pulseStart(7);
    waitDone(n);
    autoEn = 1'b0;
    startBand = 5'd9;
    @(negedge clk);
    check(activeBand == 5'd9, "R10 manual band", activeBand, 9);
    pulseStart(9);
    check(searchIdle == 1'b1 && searchOk == 1'b1, "R2 manual start ignored", searchOk, 1);
    useForce = 1'b1; forceCode = 3'b011; adcReadEn = 1'b1;
    @(negedge clk);
    adcReadEn = 1'b0; forceCode = 3'b110; adcLatch = 1'b1;
    @(negedge clk);
    adcLatch = 1'b0;
    check(adcReadback == 3'b011, "R10 latch sample", adcReadback, 3);
    adcLatch = 1'b1;
    @(negedge clk);
    adcLatch = 1'b0;
    check(adcReadback == 3'b011, "R10 no sample without read enable", adcReadback, 3);
    autoEn = 1'b1; adcReadEn = 1'b1; adcLatch = 1'b1;
    @(negedge clk);
    @(negedge clk);
    adcReadEn = 1'b0; adcLatch = 1'b0;
    check(adcReadback == 3'b011, "R10 ignored in auto", adcReadback, 3);
    useForce = 1'b0;

    // R11: manual current selection
    cpAutoMode = 1'b0;
    for (int v = 0; v < 2; v++) begin
      cpManualHigh = v[0];
      @(negedge clk);
      check(cpHigh == v[0], "R11 manual cp", cpHigh, v);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule